// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers and the status word of a processor with privileged modes. The stack pointer (r13), link register (r14) and saved status word are kept per mode. The fast-interrupt mode also has its own copy of r8 to r12. Reads always see the copies that belong to the active mode, so a mode change is a change of which copies are selected. No register contents move when the mode changes.

Exception entry happens in a single clock edge. The old status word goes into the new mode's saved status slot. The mode field is replaced and the interrupt mask bits are set. The return link is written into the new mode's r14, and the program counter is loaded with the vector address. The link and the vector are also presented on output ports. A debug port can read the r13, r14 or saved status of any mode without changing modes. Instruction decode, memory access and the choice between competing exceptions are handled outside this block.

Top module: `bankreg_top`

## Requirements
- R1: Reset state.
  - Synchronous reset gives a status word of 0x000001D3: supervisor mode, with the A, I and F mask bits set.
  - Every register reads zero.
  - The error flag is low.
- R2: Read and write timing.
  - The read ports are registered. Data for an index presented before a clock edge appears after that edge, and shows the state from before any write at the same edge.
  - r0–r7 and r15 are one shared set that all modes see.
- R3: Per-mode copies of r13, r14 and saved status.
  - The mode field is status bits [4:0]. Its legal values are user 0x10, fast interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F.
  - Each mode has its own copy, selected by slot: user and system share slot 0, supervisor 1, abort 2, undefined 3, interrupt 4, fast interrupt 5.
- R4: Fast-interrupt copies of r8–r12.
  - In fast-interrupt mode, r8–r12 come from a private copy.
  - Every other mode uses one common copy. That copy is kept intact across a fast-interrupt visit.
- R5: Mode switch to a legal target.
  - The request replaces the mode field and keeps every other status bit.
  - Switching to the mode that is already active changes nothing.
- R6: Mode switch to an illegal target.
  - The error flag goes high for exactly one cycle.
  - The mode field and all registers stay as they were.
- R7: Exception kinds, codes and status update.
  - Codes: 0 undefined, 1 supervisor call, 2 prefetch abort, 3 data abort, 4 interrupt, 5 fast interrupt.
  - On entry, the old status word is copied into the new mode's saved status slot.
  - The mode field becomes undefined, supervisor, abort (codes 2 and 3), interrupt or fast interrupt.
  - Mask bits are ORed in: I (bit 7) for codes 0 and 1; A (bit 8) and I for codes 2 to 4; A, I and F (bit 6) for code 5.
- R8: Return link. On exception entry the new mode's r14 and the link output both receive the current r15 plus an offset. The offset is 0, 0, 4, 8, 4 and 4 for codes 0 to 5.
- R9: Vector address.
  - r15 and the vector output receive a base plus offset 0x04, 0x08, 0x0C, 0x10, 0x18 or 0x1C for codes 0 to 5.
  - The base is 0 when the high-vector input is low, and 0xFFFF0000 when it is high.
- R10: Priority between requests in the same cycle.
  - While an exception request is asserted, the general write, the status write and the mode switch are all dropped.
  - A general write made in the same cycle as a mode switch goes to the copy of the mode that was active before the switch.
- R11: Debug port.
  - It is registered, with the same one-cycle timing as the read ports.
  - Selector 0 gives r13, 1 gives r14 and 2 gives the saved status of any slot 0–5.
  - Selector 3, or slot 6 or 7, returns zero.
- R12: An exception code of 6 or 7 raises the error flag for one cycle and changes no state.
- R13: A status write replaces bits [31:5] with the write data and never touches the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data, registered |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data, registered |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | General register write index |
| wr_data | input | 32 | General register write data |
| st_wr_en | input | 1 | Status flag write enable |
| st_wr_data | input | 27 | New value for status bits [31:5] |
| mode_req | input | 1 | Mode switch request |
| mode_tgt | input | 5 | Target mode code |
| exc_req | input | 1 | Exception entry request |
| exc_kind | input | 3 | Exception code |
| hivec | input | 1 | Select the high vector base |
| dbg_bank | input | 3 | Debug slot select |
| dbg_sel | input | 2 | Debug register select |
| dbg_data | output | 32 | Debug read data, registered |
| status_o | output | 32 | Current status word |
| link_o | output | 32 | Return link of the last exception entry |
| vec_o | output | 32 | Vector address of the last exception entry |
| mode_err_o | output | 1 | One-cycle pulse for an illegal mode or exception code |

## Verification
A wrong slot decode, or a wrong choice of the r8–r12 copy, does not show on the status word. It only shows when a register is read back, so the bench always reads after every operation. The error appears on the read or debug port two edges after the operation that caused it. A bad mask, mode or saved-status value shows on status_o or on the debug port in the cycle right after the exception edge. A wrong link or vector shows on link_o and vec_o at the same time. A fast-interrupt visit that corrupts the common r8–r12 copy stays hidden until the next read of those registers in a non-fast mode. Directed sequences therefore write, switch away and read back.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  localparam int MODE_W = 5;
  localparam int KIND_W = 3;
  localparam int NLO    = 8;
  localparam int NHI    = 5;
  localparam int NREG   = NLO + NHI + 3;
  localparam int IDX_W  = $clog2(NREG);
  localparam int SP_IDX = NLO + NHI;
  localparam int LR_IDX = SP_IDX + 1;
  localparam int PC_IDX = SP_IDX + 2;
  localparam int NBANK  = 6;
  localparam int BANK_W = $clog2(NBANK);
  localparam int FIQ_BANK = 5;
  localparam int A_BIT  = 8;
  localparam int I_BIT  = 7;
  localparam int F_BIT  = 6;

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13,
    M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F
  } mode_e;

  typedef enum logic [KIND_W-1:0] {
    X_UND = 3'd0, X_SVC = 3'd1, X_PABT = 3'd2,
    X_DABT = 3'd3, X_IRQ = 3'd4, X_FIQ = 3'd5
  } kind_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: mode_legal = 1'b1;
      default: mode_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bankreg_mode_dec.sv
module bankreg_mode_dec
  import bankreg_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic [BANK_W-1:0] bank_o
);
  always_comb begin
    case (mode_i)
      M_SVC:   bank_o = BANK_W'(1);
      M_ABT:   bank_o = BANK_W'(2);
      M_UND:   bank_o = BANK_W'(3);
      M_IRQ:   bank_o = BANK_W'(4);
      M_FIQ:   bank_o = BANK_W'(FIQ_BANK);
      default: bank_o = '0;
    endcase
  end
endmodule

// File: rtl/bankreg_exc_map.sv
module bankreg_exc_map
  import bankreg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [KIND_W-1:0] kind_i,
  output logic              ok_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [DW-1:0]     mask_o,
  output logic [DW-1:0]     link_off_o,
  output logic [DW-1:0]     vec_off_o
);
  localparam logic [DW-1:0] MA = DW'(1) << A_BIT;
  localparam logic [DW-1:0] MI = DW'(1) << I_BIT;
  localparam logic [DW-1:0] MF = DW'(1) << F_BIT;

  always_comb begin
    ok_o       = 1'b1;
    mode_o     = M_SVC;
    mask_o     = '0;
    link_off_o = '0;
    vec_off_o  = '0;
    case (kind_i)
      X_UND:  begin mode_o = M_UND; mask_o = MI;           vec_off_o = DW'(8'h04); end
      X_SVC:  begin mode_o = M_SVC; mask_o = MI;           vec_off_o = DW'(8'h08); end
      X_PABT: begin mode_o = M_ABT; mask_o = MA | MI;      vec_off_o = DW'(8'h0C); link_off_o = DW'(4); end
      X_DABT: begin mode_o = M_ABT; mask_o = MA | MI;      vec_off_o = DW'(8'h10); link_off_o = DW'(8); end
      X_IRQ:  begin mode_o = M_IRQ; mask_o = MA | MI;      vec_off_o = DW'(8'h18); link_off_o = DW'(4); end
      X_FIQ:  begin mode_o = M_FIQ; mask_o = MA | MI | MF; vec_off_o = DW'(8'h1C); link_off_o = DW'(4); end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
  import bankreg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] cur_bank,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DW-1:0]     rd_a_val,
  output logic [DW-1:0]     rd_b_val,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              exc_we,
  input  logic [BANK_W-1:0] exc_bank,
  input  logic [DW-1:0]     exc_link,
  input  logic [DW-1:0]     exc_spsr,
  input  logic [DW-1:0]     exc_pc,
  input  logic [BANK_W-1:0] dbg_bank,
  input  logic [1:0]        dbg_sel,
  output logic [DW-1:0]     dbg_val,
  output logic [DW-1:0]     pc_val
);
  logic [DW-1:0] lo_q     [NLO];
  logic [DW-1:0] usr_hi_q [NHI];
  logic [DW-1:0] fiq_hi_q [NHI];
  logic [DW-1:0] sp_q     [NBANK];
  logic [DW-1:0] lr_q     [NBANK];
  logic [DW-1:0] spsr_q   [NBANK];
  logic [DW-1:0] pc_q;
  logic [DW-1:0] view     [NREG];
  logic          in_fiq;

  assign in_fiq = (cur_bank == BANK_W'(FIQ_BANK));
  assign pc_val = pc_q;

  // Shared low registers and the swapped high group
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLO; i++) lo_q[i] <= '0;
      for (int i = 0; i < NHI; i++) begin
        usr_hi_q[i] <= '0;
        fiq_hi_q[i] <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < NLO; i++)
        if (wr_idx == IDX_W'(i)) lo_q[i] <= wr_data;
      for (int i = 0; i < NHI; i++)
        if (wr_idx == IDX_W'(NLO + i)) begin
          if (in_fiq) fiq_hi_q[i] <= wr_data;
          else        usr_hi_q[i] <= wr_data;
        end
    end
  end

  // Per-mode slots and the program counter
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANK; b++) begin
        sp_q[b]   <= '0;
        lr_q[b]   <= '0;
        spsr_q[b] <= '0;
      end
      pc_q <= '0;
    end else if (exc_we) begin
      lr_q[exc_bank]   <= exc_link;
      spsr_q[exc_bank] <= exc_spsr;
      pc_q             <= exc_pc;
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(SP_IDX)) sp_q[cur_bank] <= wr_data;
      if (wr_idx == IDX_W'(LR_IDX)) lr_q[cur_bank] <= wr_data;
      if (wr_idx == IDX_W'(PC_IDX)) pc_q <= wr_data;
    end
  end

  always_comb begin
    for (int i = 0; i < NLO; i++) view[i] = lo_q[i];
    for (int i = 0; i < NHI; i++) view[NLO + i] = in_fiq ? fiq_hi_q[i] : usr_hi_q[i];
    view[SP_IDX] = sp_q[cur_bank];
    view[LR_IDX] = lr_q[cur_bank];
    view[PC_IDX] = pc_q;
  end

  assign rd_a_val = view[rd_a_idx];
  assign rd_b_val = view[rd_b_idx];

  always_comb begin
    dbg_val = '0;
    if (dbg_bank < BANK_W'(NBANK)) begin
      case (dbg_sel)
        2'd0:    dbg_val = sp_q[dbg_bank];
        2'd1:    dbg_val = lr_q[dbg_bank];
        2'd2:    dbg_val = spsr_q[dbg_bank];
        default: dbg_val = '0;
      endcase
    end
  end
endmodule

// File: rtl/bankreg_top.sv
module bankreg_top
  import bankreg_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] HIVEC_BASE = 'hFFFF_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [IDX_W-1:0]     rd_a_idx,
  output logic [DW-1:0]        rd_a_data,
  input  logic [IDX_W-1:0]     rd_b_idx,
  output logic [DW-1:0]        rd_b_data,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic                 st_wr_en,
  input  logic [DW-MODE_W-1:0] st_wr_data,
  input  logic                 mode_req,
  input  logic [MODE_W-1:0]    mode_tgt,
  input  logic                 exc_req,
  input  logic [KIND_W-1:0]    exc_kind,
  input  logic                 hivec,
  input  logic [BANK_W-1:0]    dbg_bank,
  input  logic [1:0]           dbg_sel,
  output logic [DW-1:0]        dbg_data,
  output logic [DW-1:0]        status_o,
  output logic [DW-1:0]        link_o,
  output logic [DW-1:0]        vec_o,
  output logic                 mode_err_o
);
  localparam logic [DW-1:0] RST_ST = (DW'(1) << A_BIT) | (DW'(1) << I_BIT) |
                                     (DW'(1) << F_BIT) | DW'(M_SVC);

  logic [DW-1:0]     st_q;
  logic [BANK_W-1:0] cur_bank, exc_bank;
  logic              exc_ok, exc_go, tgt_ok;
  logic [MODE_W-1:0] exc_mode;
  logic [DW-1:0]     exc_mask, link_off, vec_off, pc_val, link_n, vec_n;
  logic [DW-1:0]     rd_a_val, rd_b_val, dbg_val;

  bankreg_mode_dec u_cur (.mode_i(st_q[MODE_W-1:0]), .bank_o(cur_bank));
  bankreg_mode_dec u_new (.mode_i(exc_mode), .bank_o(exc_bank));

  bankreg_exc_map #(.DW(DW)) u_map (
    .kind_i(exc_kind), .ok_o(exc_ok), .mode_o(exc_mode),
    .mask_o(exc_mask), .link_off_o(link_off), .vec_off_o(vec_off)
  );

  assign tgt_ok = mode_legal(mode_tgt);
  assign exc_go = exc_req && exc_ok;
  assign link_n = pc_val + link_off;
  assign vec_n  = (hivec ? HIVEC_BASE : '0) + vec_off;

  bankreg_store #(.DW(DW)) u_store (
    .clk(clk), .rst(rst), .cur_bank(cur_bank),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_val(rd_a_val), .rd_b_val(rd_b_val),
    .wr_en(wr_en && !exc_req), .wr_idx(wr_idx), .wr_data(wr_data),
    .exc_we(exc_go), .exc_bank(exc_bank), .exc_link(link_n),
    .exc_spsr(st_q), .exc_pc(vec_n),
    .dbg_bank(dbg_bank), .dbg_sel(dbg_sel), .dbg_val(dbg_val),
    .pc_val(pc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= RST_ST;
      link_o     <= '0;
      vec_o      <= '0;
      mode_err_o <= 1'b0;
    end else begin
      mode_err_o <= exc_req ? !exc_ok : (mode_req && !tgt_ok);
      if (exc_req) begin
        if (exc_ok) begin
          st_q   <= {st_q[DW-1:MODE_W], exc_mode} | exc_mask;
          link_o <= link_n;
          vec_o  <= vec_n;
        end
      end else begin
        if (st_wr_en) st_q[DW-1:MODE_W] <= st_wr_data;
        if (mode_req && tgt_ok) st_q[MODE_W-1:0] <= mode_tgt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_a_data <= '0;
      rd_b_data <= '0;
      dbg_data  <= '0;
    end else begin
      rd_a_data <= rd_a_val;
      rd_b_data <= rd_b_val;
      dbg_data  <= dbg_val;
    end
  end

  assign status_o = st_q;
endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk
  import bankreg_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [DW-1:0] HIVEC_BASE = 'hFFFF_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_req,
  input logic [MODE_W-1:0] mode_tgt,
  input logic              exc_req,
  input logic [KIND_W-1:0] exc_kind,
  input logic              hivec,
  input logic [DW-1:0]     status_o,
  input logic [DW-1:0]     vec_o,
  input logic              mode_err_o
);
  a_r1_reset_status: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status_o == DW'(32'h1D3)));

  a_r3_mode_always_legal: assert property (@(posedge clk) disable iff (rst)
    mode_legal(status_o[MODE_W-1:0]));

  a_r5_same_mode_kept: assert property (@(posedge clk) disable iff (rst)
    (mode_req && !exc_req && mode_tgt == status_o[MODE_W-1:0]) |=> $stable(status_o[MODE_W-1:0]));

  a_r6_bad_mode_flag: assert property (@(posedge clk) disable iff (rst)
    (mode_req && !exc_req && !mode_legal(mode_tgt)) |=> (mode_err_o && $stable(status_o[MODE_W-1:0])));

  a_r7_fiq_entry_masks: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_kind == X_FIQ) |=> (status_o[A_BIT:F_BIT] == 3'b111 && status_o[MODE_W-1:0] == M_FIQ));

  a_r9_high_vector_base: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_kind <= X_FIQ && hivec) |=> (vec_o[DW-1:5] == HIVEC_BASE[DW-1:5]));

  a_r12_bad_kind_no_change: assert property (@(posedge clk) disable iff (rst)
    (exc_req && exc_kind > X_FIQ) |=> (mode_err_o && $stable(status_o)));
endmodule

bind bankreg_top bankreg_chk #(.DW(DW), .HIVEC_BASE(HIVEC_BASE)) u_chk (
  .clk(clk), .rst(rst), .mode_req(mode_req), .mode_tgt(mode_tgt),
  .exc_req(exc_req), .exc_kind(exc_kind), .hivec(hivec),
  .status_o(status_o), .vec_o(vec_o), .mode_err_o(mode_err_o)
);

// File: tb/sim_bankreg_top.sv
module sim_bankreg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, dbg_data, status_o, link_o, vec_o;
  logic        wr_en = 1'b0, st_wr_en = 1'b0, mode_req = 1'b0, exc_req = 1'b0, hivec = 1'b0;
  logic [26:0] st_wr_data = '0;
  logic [4:0]  mode_tgt = '0;
  logic [2:0]  exc_kind = '0, dbg_bank = '0;
  logic [1:0]  dbg_sel = '0;
  logic        mode_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  bankreg_top u0 (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .mode_req(mode_req), .mode_tgt(mode_tgt), .exc_req(exc_req), .exc_kind(exc_kind),
    .hivec(hivec), .dbg_bank(dbg_bank), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .status_o(status_o), .link_o(link_o), .vec_o(vec_o), .mode_err_o(mode_err_o)
  );

  // Reference state
  logic [31:0] m_lo [8];
  logic [31:0] m_uhi [5];
  logic [31:0] m_fhi [5];
  logic [31:0] m_sp [6];
  logic [31:0] m_lr [6];
  logic [31:0] m_spsr [6];
  logic [31:0] m_pc, m_st;

  function automatic bit legal(logic [4:0] m);
    return m inside {5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
  endfunction

  function automatic int slot_of(logic [4:0] m);
    case (m)
      5'h13: return 1;
      5'h17: return 2;
      5'h1B: return 3;
      5'h12: return 4;
      5'h11: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [4:0] pick_mode(int k);
    case (k % 7)
      0: return 5'h10;
      1: return 5'h11;
      2: return 5'h12;
      3: return 5'h13;
      4: return 5'h17;
      5: return 5'h1B;
      default: return 5'h1F;
    endcase
  endfunction

  function automatic logic [4:0] kind_mode(int k);
    case (k)
      0: return 5'h1B;
      1: return 5'h13;
      2, 3: return 5'h17;
      4: return 5'h12;
      default: return 5'h11;
    endcase
  endfunction

  function automatic logic [31:0] kind_mask(int k);
    if (k <= 1) return 32'h080;
    if (k <= 4) return 32'h180;
    return 32'h1C0;
  endfunction

  function automatic logic [31:0] kind_link(int k);
    case (k)
      2: return 32'd4;
      3: return 32'd8;
      4, 5: return 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] kind_vec(int k);
    case (k)
      0: return 32'h04;
      1: return 32'h08;
      2: return 32'h0C;
      3: return 32'h10;
      4: return 32'h18;
      default: return 32'h1C;
    endcase
  endfunction

  function automatic logic [31:0] m_view(int idx);
    int s = slot_of(m_st[4:0]);
    if (idx < 8) return m_lo[idx];
    if (idx < 13) return (s == 5) ? m_fhi[idx-8] : m_uhi[idx-8];
    if (idx == 13) return m_sp[s];
    if (idx == 14) return m_lr[s];
    return m_pc;
  endfunction

  function automatic logic [31:0] m_dbg(int b, int sel);
    if (b > 5) return 32'h0;
    case (sel)
      0: return m_sp[b];
      1: return m_lr[b];
      2: return m_spsr[b];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic m_write(int idx, logic [31:0] d);
    int s = slot_of(m_st[4:0]);
    if (idx < 8) m_lo[idx] = d;
    else if (idx < 13) begin
      if (s == 5) m_fhi[idx-8] = d; else m_uhi[idx-8] = d;
    end
    else if (idx == 13) m_sp[s] = d;
    else if (idx == 14) m_lr[s] = d;
    else m_pc = d;
  endtask

  // One operation cycle, then checks of status, flag, link and vector
  task automatic apply(input string tag, input bit wr, input int wi, input logic [31:0] wd,
                       input bit sw, input logic [4:0] mt, input bit ex, input int ek,
                       input bit hv, input bit stw, input logic [26:0] sd);
    bit          e_err = 1'b0;
    bit          e_exc = 1'b0;
    logic [31:0] e_link = '0, e_vec = '0, nst;
    wr_en = wr; wr_idx = wi[3:0]; wr_data = wd;
    mode_req = sw; mode_tgt = mt; exc_req = ex; exc_kind = ek[2:0];
    hivec = hv; st_wr_en = stw; st_wr_data = sd;
    if (ex) begin
      if (ek <= 5) begin
        int s = slot_of(kind_mode(ek));
        e_exc = 1'b1;
        e_link = m_pc + kind_link(ek);
        e_vec = (hv ? 32'hFFFF_0000 : 32'h0) + kind_vec(ek);
        m_spsr[s] = m_st;
        m_lr[s] = e_link;
        m_pc = e_vec;
        m_st = {m_st[31:5], kind_mode(ek)} | kind_mask(ek);
      end else e_err = 1'b1;
    end else begin
      if (wr) m_write(wi, wd);
      nst = m_st;
      if (stw) nst[31:5] = sd;
      if (sw) begin
        if (legal(mt)) nst[4:0] = mt; else e_err = 1'b1;
      end
      m_st = nst;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; mode_req = 1'b0; exc_req = 1'b0; st_wr_en = 1'b0;
    chk({tag, " status"}, status_o, m_st);
    chk("R6/R12 error flag", {31'b0, mode_err_o}, {31'b0, e_err});
    if (e_exc) begin
      chk("R8 link", link_o, e_link);
      chk("R9 vector", vec_o, e_vec);
    end
  endtask

  // Idle cycle: both read ports and the debug port compared with the model
  task automatic readback(input string tag, input int ia, input int ib, input int db, input int ds);
    rd_a_idx = ia[3:0]; rd_b_idx = ib[3:0]; dbg_bank = db[2:0]; dbg_sel = ds[1:0];
    @(posedge clk);
    @(negedge clk);
    chk({tag, " read A"}, rd_a_data, m_view(ia));
    chk({tag, " read B"}, rd_b_data, m_view(ib));
    chk("R11 debug", dbg_data, m_dbg(db, ds));
    chk("R6 flag drops", {31'b0, mode_err_o}, 32'h0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed0 = $urandom(32'd4711);
    for (int i = 0; i < 8; i++) m_lo[i] = '0;
    for (int i = 0; i < 5; i++) begin m_uhi[i] = '0; m_fhi[i] = '0; end
    for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; m_spsr[i] = '0; end
    m_pc = '0;
    m_st = 32'h1D3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset status", status_o, 32'h1D3);
    chk("R1 reset flag", {31'b0, mode_err_o}, 32'h0);
    readback("R1", 0, 15, 1, 2);

    // R4: common r8 copy survives a fast-interrupt visit
    apply("R2", 1, 8, 32'hAAAA_0008, 0, 5'h0, 0, 0, 0, 0, '0);
    apply("R5", 0, 0, 0, 1, 5'h11, 0, 0, 0, 0, '0);
    readback("R4 fiq fresh", 8, 12, 5, 0);
    apply("R4", 1, 8, 32'hBBBB_0008, 0, 5'h0, 0, 0, 0, 0, '0);
    apply("R3", 1, 13, 32'h5555_000D, 0, 5'h0, 0, 0, 0, 0, '0);
    apply("R5", 0, 0, 0, 1, 5'h10, 0, 0, 0, 0, '0);
    readback("R4 common back", 8, 13, 5, 0);
    apply("R5", 0, 0, 0, 1, 5'h11, 0, 0, 0, 0, '0);
    readback("R4 fiq back", 8, 13, 0, 0);
    // R3: user and system share a slot
    apply("R3", 0, 0, 0, 1, 5'h1F, 0, 0, 0, 0, '0);
    apply("R3", 1, 14, 32'h1234_000E, 0, 5'h0, 0, 0, 0, 0, '0);
    apply("R3", 0, 0, 0, 1, 5'h10, 0, 0, 0, 0, '0);
    readback("R3 shared slot", 14, 13, 0, 1);
    // R5 same mode, R6 illegal mode, R13 status write
    apply("R5 same mode", 0, 0, 0, 1, 5'h10, 0, 0, 0, 0, '0);
    apply("R6 bad mode", 0, 0, 0, 1, 5'h00, 0, 0, 0, 0, '0);
    apply("R13 flags", 0, 0, 0, 0, 5'h0, 0, 0, 0, 1, 27'h7FF_FFFF);
    // R7, R8, R9 with the high base; R10 write dropped during entry
    apply("R2", 1, 15, 32'h0000_8000, 0, 5'h0, 0, 0, 0, 0, '0);
    apply("R10 exc drops write", 1, 0, 32'hDEAD_BEEF, 1, 5'h13, 1, 4, 1, 1, '0);
    readback("R10", 0, 14, 4, 2);
    apply("R7 fiq", 0, 0, 0, 0, 5'h0, 1, 5, 0, 0, '0);
    readback("R7", 15, 14, 5, 2);
    // R12 illegal kind
    apply("R12 bad kind", 1, 1, 32'h1, 0, 5'h0, 1, 7, 0, 0, '0);
    readback("R12", 1, 15, 7, 0);
    // R10: write in a switch cycle goes to the old mode's copy
    apply("R10 switch+write", 1, 13, 32'hCAFE_000D, 1, 5'h13, 0, 0, 0, 0, '0);
    readback("R10 old slot", 13, 8, 5, 0);

    // Constrained random mix
    for (int it = 0; it < 1500; it++) begin
      int op = int'($urandom % 8);
      int wi = int'($urandom % 16);
      logic [31:0] wd = $urandom;
      logic [4:0]  mt = (($urandom % 8) == 0) ? 5'($urandom) : pick_mode(int'($urandom % 7));
      int ek = (($urandom % 6) == 0) ? int'(6 + $urandom % 2) : int'($urandom % 6);
      bit hv = 1'($urandom);
      logic [26:0] sd = 27'($urandom);
      case (op)
        0, 1, 2: apply("R2", 1, wi, wd, 0, mt, 0, ek, hv, 0, sd);
        3:       apply("R5", 0, wi, wd, 1, mt, 0, ek, hv, 0, sd);
        4:       apply("R7", 0, wi, wd, 0, mt, 1, ek, hv, 0, sd);
        5:       apply("R13", 0, wi, wd, 0, mt, 0, ek, hv, 1, sd);
        6:       apply("R10", 1, wi, wd, 1, mt, 0, ek, hv, 1, sd);
        default: apply("R10", 1, wi, wd, 1, mt, 1, ek, hv, 1, sd);
      endcase
      readback("R3", int'($urandom % 16), int'($urandom % 16),
               int'($urandom % 8), int'($urandom % 4));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule